// File: doc/BRIEF.md
# Rational-Period Time-of-Day Clock

This block keeps the time for a precision timestamping path. It holds a seconds count and a nanoseconds count, and on every reference clock edge it moves forward by a programmable period. The period is a whole number of nanoseconds plus a fraction, numerator over denominator. A remainder accumulator carries the fraction from tick to tick, so long-run rates such as 2.5 ns per tick come out exact. The live time is also driven on two output buses so that nearby timestampers can capture it directly.

Software reaches the block through a plain write port and a plain read port. There is no back-pressure: every write is taken in the cycle it is presented, and read data is combinational from the read address. Writes only fill staging registers. A new period, an absolute time load and a signed nanosecond offset each take effect only when the matching bit is written to the command register. A read of the nanoseconds register captures the seconds at that instant, so the two later seconds reads agree with it.

Top module: `tod_frac_clock`

## Requirements
- R1: After reset the time is 0 s 0 ns, the period is 0 + 0/1, every staging register is zero except the staged denominator, which is 1, and all reads return zero.
- R2: On each tick the nanoseconds grow by the quotient, plus one more when the remainder plus the numerator reaches the denominator; in that case the denominator is subtracted from that sum to form the new remainder. With quotient 2, numerator 1 and denominator 2, any four consecutive ticks add exactly 10 ns.
- R3: When the nanoseconds reach 1,000,000,000 they drop by that amount and the 48-bit seconds count rises by one, carrying from the low 32 bits into the high 16 bits and wrapping from all-ones to zero.
- R4: The write registers are: address 0 quotient (bits 7:0), 1 numerator, 2 denominator, 3 load nanoseconds (bits 29:0), 4 load seconds high (bits 15:0), 5 load seconds low, 6 offset word. Writes to 0 to 2 leave the running period unchanged until a period commit. A period commit also clears the remainder.
- R5: A period commit is ignored, and the old period is kept, when the staged denominator is zero or the staged numerator is not below it.
- R6: A load commit replaces the time with the staged values. No tick is applied in that cycle, and the remainder is held.
- R7: A load commit whose staged nanoseconds are 1,000,000,000 or more is ignored, and the clock keeps ticking.
- R8: The offset word has a negative flag in bit 31 and a magnitude in bits 29:0. An offset commit adds or subtracts the magnitude, carrying or borrowing up to two seconds. No tick is applied in that cycle, and the remainder is held.
- R9: Address 7 is the command register: bit 0 commits the period, bit 1 the load, bit 2 the offset. Each bit is a single-cycle strobe that acts on the clock edge after the edge that takes the write. When the load and the offset are committed together, the load wins.
- R10: The read addresses are 0 for live nanoseconds, 1 for the seconds snapshot bits 47:32, and 2 for the snapshot bits 31:0. A read of address 0 captures the seconds into the snapshot.
- R11: The snapshot does not change between reads of address 0, even when the running seconds move on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the staging and command registers |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; captures the seconds snapshot when the address is 0 |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| tod_ns | output | 30 | Live nanoseconds |
| tod_sec | output | 48 | Live seconds |

## Verification
The hardest cases to reach are the offsets that cross two seconds in either direction, and ticks that roll the seconds across the 32-bit and 48-bit boundaries. Starting from reset, the seconds would take years of ticks to get there. The stimulus freezes the clock with a zero period and loads times just below those boundaries before it commits the largest offsets. It then uses a large quotient to cross a second within a few ticks, both before and after reading the snapshot. Random periods, loads and offsets, some with invalid denominators, numerators or nanoseconds, are checked against a cycle model kept in the bench.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned NS_W   = 30;
  localparam int unsigned ADDR_W = 3;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1000000000;

  typedef enum logic [ADDR_W-1:0] {
    A_PER_Q  = 3'd0,
    A_PER_N  = 3'd1,
    A_PER_D  = 3'd2,
    A_LD_NS  = 3'd3,
    A_LD_SHI = 3'd4,
    A_LD_SLO = 3'd5,
    A_OFFS   = 3'd6,
    A_CMD    = 3'd7
  } waddr_e;

  localparam int unsigned CMD_PER  = 0;
  localparam int unsigned CMD_LOAD = 1;
  localparam int unsigned CMD_OFFS = 2;
  localparam int unsigned OFFS_NEG_BIT = 31;

  typedef struct packed {
    logic per;
    logic load;
    logic offs;
  } strobe_t;
endpackage

// File: rtl/tod_stage_regs.sv
module tod_stage_regs
  import tod_pkg::*;
#(
  parameter int unsigned QUO_W  = 8,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned SEC_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [QUO_W-1:0]  stg_q,
  output logic [FRAC_W-1:0] stg_n,
  output logic [FRAC_W-1:0] stg_d,
  output logic [NS_W-1:0]   stg_ns,
  output logic [SEC_W-1:0]  stg_sec,
  output logic              stg_neg,
  output logic [NS_W-1:0]   stg_mag,
  output strobe_t           strb
);
  localparam int unsigned SEC_HI_W = SEC_W - 32;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q   <= '0;
      stg_n   <= '0;
      stg_d   <= FRAC_W'(1);
      stg_ns  <= '0;
      stg_sec <= '0;
      stg_neg <= 1'b0;
      stg_mag <= '0;
      strb    <= '0;
    end else begin
      strb <= '0;
      if (wr_en) begin
        case (wr_addr)
          A_PER_Q:  stg_q <= wr_data[QUO_W-1:0];
          A_PER_N:  stg_n <= wr_data[FRAC_W-1:0];
          A_PER_D:  stg_d <= wr_data[FRAC_W-1:0];
          A_LD_NS:  stg_ns <= wr_data[NS_W-1:0];
          A_LD_SHI: stg_sec[SEC_W-1:32] <= wr_data[SEC_HI_W-1:0];
          A_LD_SLO: stg_sec[31:0] <= wr_data;
          A_OFFS: begin
            stg_neg <= wr_data[OFFS_NEG_BIT];
            stg_mag <= wr_data[NS_W-1:0];
          end
          A_CMD: begin
            strb.per  <= wr_data[CMD_PER];
            strb.load <= wr_data[CMD_LOAD];
            strb.offs <= wr_data[CMD_OFFS];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tod_frac_acc.sv
module tod_frac_acc #(
  parameter int unsigned QUO_W  = 8,
  parameter int unsigned FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [QUO_W-1:0]  new_q,
  input  logic [FRAC_W-1:0] new_n,
  input  logic [FRAC_W-1:0] new_d,
  input  logic              advance,
  output logic [QUO_W:0]    inc
);
  logic [QUO_W-1:0]  quo_q;
  logic [FRAC_W-1:0] num_q, den_q, rem_q;
  logic [FRAC_W:0]   sum, sum_less;
  logic              carry, cfg_ok;

  assign cfg_ok   = (new_d != '0) && (new_n < new_d);
  assign sum      = {1'b0, rem_q} + {1'b0, num_q};
  assign carry    = sum >= {1'b0, den_q};
  assign sum_less = sum - {1'b0, den_q};
  assign inc      = {1'b0, quo_q} + (QUO_W+1)'(carry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      num_q <= '0;
      den_q <= FRAC_W'(1);
      rem_q <= '0;
    end else if (commit && cfg_ok) begin
      quo_q <= new_q;
      num_q <= new_n;
      den_q <= new_d;
      rem_q <= '0;
    end else if (advance) begin
      rem_q <= carry ? sum_less[FRAC_W-1:0] : sum[FRAC_W-1:0];
    end
  end

  // R5: the running denominator is never zero
  a_r5_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    den_q != '0);
  // R2: the remainder stays below the denominator
  a_r2_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q < den_q);
  // R5: a rejected commit keeps the old period
  a_r5_bad_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cfg_ok) |=> ($stable(den_q) && $stable(num_q) && $stable(quo_q)));
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
  import tod_pkg::*;
#(
  parameter int unsigned QUO_W = 8,
  parameter int unsigned SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NS_W-1:0]  ld_ns,
  input  logic [SEC_W-1:0] ld_sec,
  input  logic             adj,
  input  logic             adj_neg,
  input  logic [NS_W-1:0]  adj_mag,
  input  logic [QUO_W:0]   inc,
  output logic [NS_W-1:0]  ns_q,
  output logic [SEC_W-1:0] sec_q
);
  localparam logic [NS_W:0] ONE_SEC = {1'b0, NS_PER_SEC};
  localparam logic [NS_W:0] TWO_SEC = {NS_PER_SEC, 1'b0};

  logic [NS_W:0]   tick_sum, tick_m1, pos_sum, pos_m1, pos_m2;
  logic [NS_W+1:0] dn0, dn1, dn2;
  logic [NS_W-1:0] nxt_ns;
  logic [2:0]      step;
  logic [SEC_W-1:0] nxt_sec;

  assign tick_sum = {1'b0, ns_q} + {{(NS_W-QUO_W){1'b0}}, inc};
  assign tick_m1  = tick_sum - ONE_SEC;
  assign pos_sum  = {1'b0, ns_q} + {1'b0, adj_mag};
  assign pos_m1   = pos_sum - ONE_SEC;
  assign pos_m2   = pos_sum - TWO_SEC;
  assign dn0      = {2'b00, ns_q} - {2'b00, adj_mag};
  assign dn1      = dn0 + {1'b0, ONE_SEC};
  assign dn2      = dn0 + {1'b0, TWO_SEC};

  always_comb begin
    nxt_ns = ns_q;
    step   = 3'd0;
    if (load) begin
      nxt_ns = ld_ns;
    end else if (adj) begin
      if (!adj_neg) begin
        if (pos_sum >= TWO_SEC)      begin nxt_ns = pos_m2[NS_W-1:0]; step = 3'd2; end
        else if (pos_sum >= ONE_SEC) begin nxt_ns = pos_m1[NS_W-1:0]; step = 3'd1; end
        else                               nxt_ns = pos_sum[NS_W-1:0];
      end else begin
        if (!dn0[NS_W+1])      nxt_ns = dn0[NS_W-1:0];
        else if (!dn1[NS_W+1]) begin nxt_ns = dn1[NS_W-1:0]; step = 3'b111; end
        else                   begin nxt_ns = dn2[NS_W-1:0]; step = 3'b110; end
      end
    end else if (tick_sum >= ONE_SEC) begin
      nxt_ns = tick_m1[NS_W-1:0];
      step   = 3'd1;
    end else begin
      nxt_ns = tick_sum[NS_W-1:0];
    end
    nxt_sec = load ? ld_sec : sec_q + {{(SEC_W-3){step[2]}}, step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else begin
      ns_q  <= nxt_ns;
      sec_q <= nxt_sec;
    end
  end

  // R3: nanoseconds always stay below one second
  a_r3_ns_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ns_q < NS_PER_SEC);
  // R3: a plain tick moves the seconds by at most one
  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adj) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SEC_W'(1)));
endmodule

// File: rtl/tod_frac_clock.sv
module tod_frac_clock
  import tod_pkg::*;
#(
  parameter int unsigned QUO_W  = 8,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned SEC_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NS_W-1:0]   tod_ns,
  output logic [SEC_W-1:0]  tod_sec
);
  localparam int unsigned SEC_HI_W = SEC_W - 32;

  logic [QUO_W-1:0]  stg_q;
  logic [FRAC_W-1:0] stg_n, stg_d;
  logic [NS_W-1:0]   stg_ns, stg_mag;
  logic [SEC_W-1:0]  stg_sec, snap_sec;
  logic              stg_neg, load_go, adj_go;
  logic [QUO_W:0]    inc;
  strobe_t           strb;

  tod_stage_regs #(.QUO_W(QUO_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stg_q(stg_q), .stg_n(stg_n), .stg_d(stg_d), .stg_ns(stg_ns), .stg_sec(stg_sec),
    .stg_neg(stg_neg), .stg_mag(stg_mag), .strb(strb));

  assign load_go = strb.load && (stg_ns < NS_PER_SEC);
  assign adj_go  = strb.offs && !load_go;

  tod_frac_acc #(.QUO_W(QUO_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .commit(strb.per), .new_q(stg_q), .new_n(stg_n),
    .new_d(stg_d), .advance(!(load_go || adj_go)), .inc(inc));

  tod_time_core #(.QUO_W(QUO_W), .SEC_W(SEC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load_go), .ld_ns(stg_ns), .ld_sec(stg_sec),
    .adj(adj_go), .adj_neg(stg_neg), .adj_mag(stg_mag), .inc(inc),
    .ns_q(tod_ns), .sec_q(tod_sec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            snap_sec <= '0;
    else if (rd_en && rd_addr == ADDR_W'(0)) snap_sec <= tod_sec;
  end

  always_comb begin
    case (rd_addr)
      ADDR_W'(0): rd_data = {{(32-NS_W){1'b0}}, tod_ns};
      ADDR_W'(1): rd_data = {{(32-SEC_HI_W){1'b0}}, snap_sec[SEC_W-1:32]};
      ADDR_W'(2): rd_data = snap_sec[31:0];
      default:    rd_data = '0;
    endcase
  end

  // R6: a valid load replaces the time on the following edge
  a_r6_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (tod_ns == $past(stg_ns) && tod_sec == $past(stg_sec)));
  // R11: the snapshot only moves on a nanoseconds read
  a_r11_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == ADDR_W'(0)) |=> $stable(snap_sec));
endmodule

// File: tb/tod_frac_clock_test.sv
`timescale 1ns/1ps
module tod_frac_clock_test;
  localparam longint NS1 = 1000000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [29:0] tod_ns;
  logic [47:0] tod_sec;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rd_sample;

  // bench model
  longint m_ns = 0, m_q = 0, m_n = 0, m_d = 1, m_acc = 0;
  logic [47:0] m_sec = '0, m_snap = '0, s_sec = '0;
  longint s_q = 0, s_n = 0, s_d = 1, s_ns = 0, s_mag = 0;
  bit s_neg = 0, p_per = 0, p_load = 0, p_offs = 0;

  tod_frac_clock uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tod_ns(tod_ns), .tod_sec(tod_sec));

  always #2.5 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step(bit we, logic [2:0] wa, logic [31:0] wd, bit re, logic [2:0] ra);
    longint sum, inc, t;
    bit carry, ldgo, adgo, perok;
    if (re && ra == 3'd0) m_snap = m_sec;
    ldgo = p_load && (s_ns < NS1);
    adgo = p_offs && !ldgo;
    sum = m_acc + m_n;
    carry = (sum >= m_d);
    inc = m_q + longint'(carry);
    if (ldgo) begin
      m_ns = s_ns; m_sec = s_sec;
    end else if (adgo) begin
      t = s_neg ? m_ns - s_mag : m_ns + s_mag;
      while (t >= NS1) begin t -= NS1; m_sec += 48'd1; end
      while (t < 0) begin t += NS1; m_sec -= 48'd1; end
      m_ns = t;
    end else begin
      m_ns += inc;
      if (m_ns >= NS1) begin m_ns -= NS1; m_sec += 48'd1; end
    end
    perok = p_per && s_d != 0 && s_n < s_d;
    if (perok) begin
      m_q = s_q; m_n = s_n; m_d = s_d; m_acc = 0;
    end else if (!(ldgo || adgo)) begin
      m_acc = carry ? sum - m_d : sum;
    end
    p_per = 0; p_load = 0; p_offs = 0;
    if (we) begin
      case (wa)
        3'd0: s_q = longint'(wd[7:0]);
        3'd1: s_n = longint'(wd);
        3'd2: s_d = longint'(wd);
        3'd3: s_ns = longint'(wd[29:0]);
        3'd4: s_sec[47:32] = wd[15:0];
        3'd5: s_sec[31:0] = wd;
        3'd6: begin s_neg = wd[31]; s_mag = longint'(wd[29:0]); end
        default: begin p_per = wd[0]; p_load = wd[1]; p_offs = wd[2]; end
      endcase
    end
  endtask

  task automatic cyc(bit we, logic [2:0] wa, logic [31:0] wd, bit re, logic [2:0] ra);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    #1;
    rd_sample = rd_data;
    @(posedge clk);
    model_step(we, wa, wd, re, ra);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d); cyc(1, a, d, 0, 3'd0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 3'd0, 0, 0, 3'd0); endtask

  task automatic read_time(string tag);
    longint e_ns;
    logic [47:0] e_sec;
    e_ns = m_ns; e_sec = m_sec;
    chk({tag, " R10 port ns"}, longint'(tod_ns), e_ns);
    cyc(0, 3'd0, 0, 1, 3'd0);
    chk({tag, " R10 read ns"}, longint'(rd_sample), e_ns);
    cyc(0, 3'd0, 0, 1, 3'd1);
    chk({tag, " R10 read sec hi"}, longint'(rd_sample), longint'(e_sec[47:32]));
    cyc(0, 3'd0, 0, 1, 3'd2);
    chk({tag, " R11 read sec lo"}, longint'(rd_sample), longint'(e_sec[31:0]));
  endtask

  task automatic set_period(longint q, longint n, longint d);
    wr(3'd0, 32'(q)); wr(3'd1, 32'(n)); wr(3'd2, 32'(d)); wr(3'd7, 32'h1);
    idle(1);
  endtask

  task automatic load_time(longint ns, logic [47:0] sec);
    wr(3'd3, 32'(ns)); wr(3'd4, {16'h0, sec[47:32]}); wr(3'd5, sec[31:0]); wr(3'd7, 32'h2);
  endtask

  task automatic offset(bit neg, longint mag);
    wr(3'd6, {neg, 1'b0, mag[29:0]}); wr(3'd7, 32'h4);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=%0d exp=0", 1);
      summary();
      $finish;
    end
  end

  initial begin
    longint a, b, q, n, d, ns, mag;
    int seed;
    seed = $urandom(32'h1d5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    read_time("R1 reset");
    idle(5);
    chk("R1 frozen ns", longint'(tod_ns), 0);
    // R4 staged period has no effect before commit
    wr(3'd0, 32'd100); wr(3'd1, 0); wr(3'd2, 1); idle(4);
    chk("R4 staged only", longint'(tod_ns), 0);
    // R2 2.5 ns period
    set_period(2, 1, 2); idle(2);
    a = longint'(tod_ns); idle(4); b = longint'(tod_ns);
    chk("R2 four ticks 2.5ns", b - a, 10);
    read_time("R2 model");
    // R5 zero denominator and numerator >= denominator rejected
    set_period(7, 0, 0); idle(2);
    a = longint'(tod_ns); idle(4); b = longint'(tod_ns);
    chk("R5 den zero kept", b - a, 10);
    set_period(9, 5, 5); idle(2);
    a = longint'(tod_ns); idle(4); b = longint'(tod_ns);
    chk("R5 num>=den kept", b - a, 10);
    // R6 load drops the tick, R9 acts one edge after the command write
    set_period(3, 0, 1);
    load_time(100, 48'd1);
    chk("R9 not yet loaded", longint'(tod_sec), longint'(m_sec));
    idle(1);
    chk("R6 loaded ns", longint'(tod_ns), 100);
    idle(1);
    chk("R6 next tick", longint'(tod_ns), 103);
    // R3 carry into the high seconds and 48-bit wrap
    set_period(200, 0, 1);
    load_time(999999900, 48'h0000_FFFF_FFFF); idle(2);
    chk("R3 hi carry sec", longint'(tod_sec), 64'h1_0000_0000);
    chk("R3 hi carry ns", longint'(tod_ns), 100);
    read_time("R3 hi carry");
    load_time(999999900, 48'hFFFF_FFFF_FFFF); idle(2);
    chk("R3 wrap sec", longint'(tod_sec), 0);
    // R7 invalid load ignored
    load_time(NS1, 48'd7); idle(2);
    chk("R7 load ignored", longint'(tod_sec), 0);
    read_time("R7 model");
    // R11 snapshot holds across a second boundary
    load_time(999999000, 48'd5); idle(1);
    cyc(0, 3'd0, 0, 1, 3'd0);
    idle(10);
    chk("R11 live moved", longint'(tod_sec), 6);
    cyc(0, 3'd0, 0, 1, 3'd2);
    chk("R11 snapshot lo", longint'(rd_sample), 5);
    cyc(0, 3'd0, 0, 1, 3'd1);
    chk("R11 snapshot hi", longint'(rd_sample), 0);
    // R8 offsets crossing two seconds, clock frozen
    set_period(0, 0, 1);
    load_time(999999999, 48'd10); idle(1);
    offset(0, 30'h3FFF_FFFF); idle(1);
    chk("R8 pos sec", longint'(tod_sec), 12);
    chk("R8 pos ns", longint'(tod_ns), 73741822);
    offset(1, 30'h3FFF_FFFF); idle(1);
    chk("R8 neg sec", longint'(tod_sec), 10);
    chk("R8 neg ns", longint'(tod_ns), 999999999);
    // R9 load beats offset
    wr(3'd3, 5); wr(3'd4, 0); wr(3'd5, 3); wr(3'd6, 7); wr(3'd7, 32'h6); idle(1);
    chk("R9 load wins ns", longint'(tod_ns), 5);
    wr(3'd7, 32'h4); idle(1);
    chk("R9 offset alone", longint'(tod_ns), 12);
    // random mix
    for (int it = 0; it < 300; it++) begin
      case ($urandom % 4)
        0: begin
          q = $urandom % 16;
          d = ($urandom % 3 == 0) ? longint'($urandom | 1) : 1 + $urandom % 1000;
          n = longint'($urandom) % d;
          if ($urandom % 8 == 0) d = 0;
          if ($urandom % 8 == 0) n = d;
          set_period(q, n, d);
        end
        1: begin
          ns = ($urandom % 6 == 0) ? NS1 + $urandom % 50 : $urandom % NS1;
          load_time(ns, {16'($urandom), 32'($urandom)});
        end
        2: begin
          mag = longint'($urandom % (1 << 30));
          offset(1'($urandom), mag);
        end
        default: idle(1 + $urandom % 30);
      endcase
      idle($urandom % 3);
      read_time("R2 R8 random");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule